// File: doc/BRIEF.md
# Saturating Error Integrator with Hysteresis Polarity Decision

This block is the digital front end of one loop of a multilevel sigma-delta modulator. Each time a sample-enable pulse arrives, it captures a signed reference word, a signed measured-output word and three settings: a gain, a clamp limit and a hysteresis half-width. It subtracts the measurement from the reference and multiplies the difference by the gain at full precision. It adds the scaled error to an integrator that is clamped to plus or minus the limit. It then turns the integrator value into a one-bit polarity decision (+1 or −1) through a comparator with hysteresis.

All words are signed fixed point with `FRAC` fractional bits, which is 16 by default within a 24-bit word. This format can hold a gain of 10, a clamp of 0.005 (328 LSB) and a hysteresis of 0.0001 (7 LSB). The level sequencer needs two error polarities, so the surrounding design uses two instances. The sample pulse rate should be at least thirty times the frequency of the reference waveform.

A four-state controller steps through each update. The states are `ST_IDLE`, `ST_MUL`, `ST_ACC` and `ST_CMP`:
- `ST_IDLE` waits. In this state a sample-enable pulse is accepted, the operands and settings are captured, and the controller moves to `ST_MUL`.
- `ST_MUL` forms the scaled error and always moves to `ST_ACC`.
- `ST_ACC` updates the clamped integrator and always moves to `ST_CMP`.
- `ST_CMP` updates the polarity decision and always returns to `ST_IDLE`.

The `pol_val` strobe is registered on the transition from `ST_CMP` back to `ST_IDLE`.

Top module: `sd_hyst_quant`

## Requirements
- R1: After reset the integrator output is 0, `pol_pos` is 1 (decision +1) and `pol_val` is 0.
- R2: The scaled error equals (ref − meas) × gain computed at full width and then shifted arithmetically right by FRAC bits, which rounds toward minus infinity. Values are two's complement words of DW bits with FRAC = 16 fractional bits.
- R3: The new integrator value is the old value plus the scaled error, clamped to the range [−limit, +limit]. The limit is a nonnegative word.
- R4: `pol_pos` = 1 encodes +1 and `pol_pos` = 0 encodes −1. A +1 decision becomes −1 only when the integrator is strictly below −H. A −1 decision becomes +1 only when it is strictly above +H.
- R5: When the integrator lies in [−H, +H] after an update, the decision keeps its previous value.
- R6: A sample-enable pulse accepted at clock edge n makes `pol_val` high for exactly one cycle, following edge n+3. The new integrator value and the new decision are visible in that same cycle.
- R7: A sample-enable pulse that arrives while an update is in progress is ignored. It produces no extra strobe and does not change the result.
- R8: Without an accepted sample-enable pulse, the integrator output and the decision hold their values.
- R9: The gain, limit and hysteresis are captured with the sample. Changing them while an update is in progress has no effect on that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | One-cycle pulse that starts an update |
| ref_in | input | DW | Reference sample, signed fixed point |
| meas_in | input | DW | Measured output sample, signed fixed point |
| gain_in | input | DW | Loop gain, signed fixed point |
| limit_in | input | DW | Integrator clamp magnitude, nonnegative |
| hyst_in | input | DW | Hysteresis half-width, nonnegative |
| integ_out | output | DW | Current integrator value |
| pol_pos | output | 1 | Decision: 1 means +1, 0 means −1 |
| pol_val | output | 1 | One-cycle strobe after each completed update |

## Verification
The bench builds the block with DW = 24 and FRAC = 16, so the example settings (gain 10, clamp 0.005, hysteresis 0.0001) are exact or nearly exact words. With these values the integrator reaches both clamp rails within a few samples. A handful of one-LSB steps then place it just inside and just outside the 7-LSB band. Fractional gains of 0.5 and 1.5 on odd differences show the floor rounding on both signs. A zero hysteresis and a widened clamp exercise the settings capture.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_ACC  = 2'd2,
        ST_CMP  = 2'd3
    } sdq_state_e;
endpackage

// File: rtl/sdq_ctrl.sv
module sdq_ctrl
    import sdq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_en,
    output sdq_state_e state,
    output logic       cap_en,
    output logic       mul_en,
    output logic       acc_en,
    output logic       cmp_en,
    output logic       val_q
);
    sdq_state_e state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (sample_en) state_nx = ST_MUL;
            ST_MUL:  state_nx = ST_ACC;
            ST_ACC:  state_nx = ST_CMP;
            ST_CMP:  state_nx = ST_IDLE;
        endcase
    end

    // stage enables
    always_comb begin
        cap_en = 1'b0;
        mul_en = 1'b0;
        acc_en = 1'b0;
        cmp_en = 1'b0;
        unique case (state)
            ST_IDLE: cap_en = sample_en;
            ST_MUL:  mul_en = 1'b1;
            ST_ACC:  acc_en = 1'b1;
            ST_CMP:  cmp_en = 1'b1;
        endcase
    end

    // completion strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= 1'b0;
        else        val_q <= cmp_en;
    end
endmodule

// File: rtl/sdq_scaler.sv
module sdq_scaler #(
    parameter int DW   = 24,
    parameter int FRAC = 16,
    localparam int PW  = 2 * DW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_en,
    input  logic                 mul_en,
    input  logic signed [DW-1:0] ref_in,
    input  logic signed [DW-1:0] meas_in,
    input  logic signed [DW-1:0] gain_in,
    output logic signed [PW-1:0] scaled_q
);
    logic signed [DW:0]   diff_q;
    logic signed [DW-1:0] gain_q;
    logic signed [DW:0]   diff_nx;
    logic signed [PW-1:0] prod_full;

    assign diff_nx   = (DW+1)'(ref_in) - (DW+1)'(meas_in);
    assign prod_full = PW'(diff_q) * PW'(gain_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            diff_q <= '0;
            gain_q <= '0;
        end else if (cap_en) begin
            diff_q <= diff_nx;
            gain_q <= gain_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      scaled_q <= '0;
        else if (mul_en) scaled_q <= prod_full >>> FRAC;
    end
endmodule

// File: rtl/sdq_integ.sv
module sdq_integ #(
    parameter int DW  = 24,
    localparam int PW = 2 * DW + 1,
    localparam int SW = PW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_en,
    input  logic                 acc_en,
    input  logic signed [DW-1:0] limit_in,
    input  logic signed [PW-1:0] scaled_q,
    output logic signed [DW-1:0] lim_q,
    output logic signed [DW-1:0] integ_q
);
    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] hi;
    logic signed [SW-1:0] lo;
    logic signed [DW-1:0] clamped;

    assign sum = SW'(integ_q) + SW'(scaled_q);
    assign hi  = SW'(lim_q);
    assign lo  = -SW'(lim_q);

    always_comb begin
        if (sum > hi)      clamped = lim_q;
        else if (sum < lo) clamped = DW'(lo);
        else               clamped = DW'(sum);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lim_q <= '0;
        else if (cap_en) lim_q <= limit_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      integ_q <= '0;
        else if (acc_en) integ_q <= clamped;
    end
endmodule

// File: rtl/sdq_hyst.sv
module sdq_hyst #(
    parameter int DW = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_en,
    input  logic                 cmp_en,
    input  logic signed [DW-1:0] hyst_in,
    input  logic signed [DW-1:0] integ_q,
    output logic signed [DW-1:0] thr_q,
    output logic                 pol_q
);
    logic signed [DW:0] x;
    logic signed [DW:0] up;
    logic signed [DW:0] dn;
    logic               pol_nx;

    assign x  = (DW+1)'(integ_q);
    assign up = (DW+1)'(thr_q);
    assign dn = -(DW+1)'(thr_q);

    always_comb begin
        pol_nx = pol_q;
        if (pol_q && (x < dn))       pol_nx = 1'b0;
        else if (!pol_q && (x > up)) pol_nx = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      thr_q <= '0;
        else if (cap_en) thr_q <= hyst_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pol_q <= 1'b1;
        else if (cmp_en) pol_q <= pol_nx;
    end
endmodule

// File: rtl/sd_hyst_quant.sv
module sd_hyst_quant
    import sdq_pkg::*;
#(
    parameter int DW   = 24,
    parameter int FRAC = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_en,
    input  logic signed [DW-1:0] ref_in,
    input  logic signed [DW-1:0] meas_in,
    input  logic signed [DW-1:0] gain_in,
    input  logic signed [DW-1:0] limit_in,
    input  logic signed [DW-1:0] hyst_in,
    output logic signed [DW-1:0] integ_out,
    output logic                 pol_pos,
    output logic                 pol_val
);
    localparam int PW = 2 * DW + 1;

    sdq_state_e           state;
    logic                 cap_en;
    logic                 mul_en;
    logic                 acc_en;
    logic                 cmp_en;
    logic signed [PW-1:0] scaled_q;
    logic signed [DW-1:0] lim_q;
    logic signed [DW-1:0] thr_q;

    sdq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .state     (state),
        .cap_en    (cap_en),
        .mul_en    (mul_en),
        .acc_en    (acc_en),
        .cmp_en    (cmp_en),
        .val_q     (pol_val)
    );

    sdq_scaler #(.DW(DW), .FRAC(FRAC)) u_scaler (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .mul_en   (mul_en),
        .ref_in   (ref_in),
        .meas_in  (meas_in),
        .gain_in  (gain_in),
        .scaled_q (scaled_q)
    );

    sdq_integ #(.DW(DW)) u_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .acc_en   (acc_en),
        .limit_in (limit_in),
        .scaled_q (scaled_q),
        .lim_q    (lim_q),
        .integ_q  (integ_out)
    );

    sdq_hyst #(.DW(DW)) u_hyst (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .cmp_en  (cmp_en),
        .hyst_in (hyst_in),
        .integ_q (integ_out),
        .thr_q   (thr_q),
        .pol_q   (pol_pos)
    );
endmodule

// File: rtl/sdq_chk.sv
module sdq_chk
    import sdq_pkg::*;
#(
    parameter int DW = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pol_val,
    input logic                 pol_pos,
    input logic signed [DW-1:0] integ_out,
    input logic signed [DW-1:0] lim_q,
    input logic signed [DW-1:0] thr_q,
    input sdq_state_e           state
);
    // R3
    in_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pol_val |-> ((DW+1)'(integ_out) <= (DW+1)'(lim_q)) &&
                    ((DW+1)'(integ_out) >= -(DW+1)'(lim_q)));

    // R6
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pol_val |=> !pol_val);

    // R4
    flip_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_val && !pol_pos && $past(pol_pos)) |->
            ((DW+1)'(integ_out) < -(DW+1)'(thr_q)));

    // R4
    flip_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_val && pol_pos && !$past(pol_pos)) |->
            ((DW+1)'(integ_out) > (DW+1)'(thr_q)));

    // R8
    pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pol_val |-> $stable(pol_pos));

    // R8
    integ_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(integ_out) |-> (state == ST_CMP));
endmodule

bind sd_hyst_quant sdq_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pol_val   (pol_val),
    .pol_pos   (pol_pos),
    .integ_out (integ_out),
    .lim_q     (lim_q),
    .thr_q     (thr_q),
    .state     (state)
);

// File: tb/sd_hyst_quant_bench.sv
module sd_hyst_quant_bench;
    localparam int  DW     = 24;
    localparam int  FRAC   = 16;
    localparam time TCLK   = 10ns;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sample_en = 1'b0;
    logic signed [DW-1:0] ref_in = '0;
    logic signed [DW-1:0] meas_in = '0;
    logic signed [DW-1:0] gain_in = '0;
    logic signed [DW-1:0] limit_in = '0;
    logic signed [DW-1:0] hyst_in = '0;
    logic signed [DW-1:0] integ_out;
    logic                 pol_pos;
    logic                 pol_val;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        longint integ;
        bit     pol;
        string  tag;
    } exp_t;
    exp_t sb[$];

    longint m_integ = 0;
    bit     m_pol   = 1'b1;

    always #(TCLK/2) clk = ~clk;

    sd_hyst_quant #(.DW(DW), .FRAC(FRAC)) u_sd_hyst_quant (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .ref_in    (ref_in),
        .meas_in   (meas_in),
        .gain_in   (gain_in),
        .limit_in  (limit_in),
        .hyst_in   (hyst_in),
        .integ_out (integ_out),
        .pol_pos   (pol_pos),
        .pol_val   (pol_val)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pop and compare on every strobe
    always @(negedge clk) begin
        if (rst_n && pol_val && !done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7 unexpected strobe", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(longint'(integ_out) == e.integ, e.tag, longint'(integ_out), e.integ);
                check(pol_pos == e.pol, {e.tag, " R4 polarity"}, longint'(pol_pos), longint'(e.pol));
            end
        end
    end

    // driver: models R2/R3/R4/R5, pushes expectation, checks R6 timing
    task automatic run_sample(input longint r, input longint m, input longint g,
                              input longint l, input longint t, input string tag,
                              input bit disturb);
        longint d, s, sum;
        exp_t e;
        d = r - m;
        s = (d * g) >>> FRAC;
        sum = m_integ + s;
        if (sum > l) sum = l;
        else if (sum < -l) sum = -l;
        m_integ = sum;
        if (m_pol && (sum < -t)) m_pol = 1'b0;
        else if (!m_pol && (sum > t)) m_pol = 1'b1;
        e.integ = m_integ;
        e.pol = m_pol;
        e.tag = tag;
        sb.push_back(e);

        @(negedge clk);
        ref_in = DW'(r); meas_in = DW'(m); gain_in = DW'(g);
        limit_in = DW'(l); hyst_in = DW'(t);
        sample_en = 1'b1;
        @(negedge clk);
        if (disturb) begin
            // R7 / R9: new pulse and new operands and settings mid-update
            ref_in = 24'sd500000; meas_in = -24'sd500000; gain_in = 24'sd3000000;
            limit_in = 24'sd100; hyst_in = 24'sd4000;
        end else begin
            sample_en = 1'b0;
        end
        @(negedge clk);
        sample_en = 1'b0;
        check(pol_val == 1'b0, "R6 strobe early", longint'(pol_val), 0);
        @(negedge clk);
        check(pol_val == 1'b0, "R6 strobe early", longint'(pol_val), 0);
        @(negedge clk);
        check(pol_val == 1'b1, "R6 strobe missing", longint'(pol_val), 1);
        @(negedge clk);
        check(pol_val == 1'b0, "R6 strobe longer than one cycle", longint'(pol_val), 0);
        repeat (4) begin
            @(negedge clk);
            check(pol_val == 1'b0, "R7 extra strobe", longint'(pol_val), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(integ_out == '0, "R1 integrator", longint'(integ_out), 0);
        check(pol_pos == 1'b1, "R1 polarity", longint'(pol_pos), 1);
        check(pol_val == 1'b0, "R1 strobe", longint'(pol_val), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // gain 10 = 655360, clamp 0.005 = 328, hysteresis 0.0001 = 7
        run_sample(66, 0, 655360, 328, 7, "R3 clamp high", 1'b0);
        run_sample(0, 20, 655360, 328, 7, "R2 scaled step down", 1'b0);
        run_sample(0, 20, 655360, 328, 7, "R4 flip to -1", 1'b0);
        run_sample(7, 0, 655360, 328, 7, "R5 hold inside band", 1'b0);
        run_sample(1, 0, 655360, 328, 7, "R4 flip to +1", 1'b0);
        run_sample(-1, 0, 655360, 328, 7, "R5 hold inside band", 1'b0);
        run_sample(0, 1000, 655360, 328, 7, "R3 clamp low", 1'b0);

        // R8: idle cycles change nothing
        repeat (12) @(negedge clk);
        check(longint'(integ_out) == m_integ, "R8 integrator hold", longint'(integ_out), m_integ);
        check(pol_pos == m_pol, "R8 polarity hold", longint'(pol_pos), longint'(m_pol));

        // R2 floor rounding with fractional gains, R9 widened clamp
        run_sample(-3, 0, 32768, 5000, 7, "R2 floor negative", 1'b0);
        run_sample(3, 0, 98304, 5000, 7, "R2 floor positive", 1'b0);
        run_sample(-2, 1, -32768, 5000, 7, "R2 negative gain", 1'b0);

        // R7 and R9: disturbing pulse and settings during the update
        run_sample(40, 0, 655360, 5000, 0, "R7 R9 ignored mid-update", 1'b1);
        run_sample(-37, 0, 655360, 5000, 0, "R4 zero band flip", 1'b1);
        run_sample(0, 0, 655360, 328, 7, "R3 clamp tightened", 1'b0);

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R6 missing results", longint'(sb.size()), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule